// File: doc/BRIEF.md
# Expansion Slot ROM Decoder

This block is the glue between an 8-bit expansion slot and a peripheral card that carries a slow EPROM. Its only clock is the slot's roughly 7 MHz reference. The three active-low slot strobes (device select, I/O select and I/O strobe) arrive late and unaligned with that clock. Each strobe passes through a synchronizer and a two-sample qualifier before any logic uses it.

The EPROM address is built without a clock, straight from the bus address. Address line A11 picks the mapping. With A11 low (the slot's own 0xCn00 page), the upper ROM bits are forced to the top page 0x700. With A11 high (the shared 0xC800 to 0xCEFF window), the eleven low bits pass through unchanged. This gives the EPROM its whole access time.

An expansion-ROM flag is set when this slot is selected and is cleared by any strobe access to 0xCFFF. While the flag is set, the card answers in the shared window. The data-bus transceiver is enabled one clock after the ROM window opens, and it drops at the same moment the window closes. This keeps the card off the bus while another driver may still be present.

Top module: `slot_rom_glue`

## Requirements
- R1: A strobe counts as active only after the third rising clock edge at which it has been sampled low. It stops counting as active after the second rising edge at which it has been sampled high.
- R2: A strobe that is low for a single clock period is never qualified. After such a glitch on I/O select, the ROM enables stay high and the expansion flag stays clear.
- R3: Output `dev_sel_act` is high exactly while the device-select strobe is qualified active.
- R4: When address bit 11 is 0, `rom_addr` equals {3'b111, addr[7:0]}, so the access always lands in ROM page 0x700.
- R5: When address bit 11 is 1, `rom_addr` equals addr[10:0]. `rom_addr` follows the address combinationally, with no clock edge needed.
- R6: The expansion flag `exp_rom_en` becomes 1 at the first clock edge at which I/O select is qualified active.
- R7: A qualified I/O strobe with address 0xCFFF clears `exp_rom_en` at the next edge. That access itself does not enable the ROM. The clear takes priority over a set.
- R8: `rom_ce_n` and `rom_oe_n` are low in two cases: while I/O select is qualified, or while the I/O strobe is qualified with the flag set, bit 11 equal to 1 and the address not 0xCFFF. In all other cases they are high.
- R9: `bus_drv_n` is high in the first cycle of each ROM enable window. It goes low one cycle later. It returns high in the same cycle that the ROM enables return high.
- R10: While `rst_n` is low, `rom_ce_n`, `rom_oe_n` and `bus_drv_n` are high, and `dev_sel_act` and `exp_rom_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_7m | input | 1 | Slot reference clock, the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel_n | input | 1 | Device select strobe, active low, asynchronous |
| io_sel_n | input | 1 | Slot I/O select strobe, active low, asynchronous |
| io_stb_n | input | 1 | Shared I/O strobe, active low, asynchronous |
| addr | input | 16 | Bus address |
| rom_addr | output | 11 | EPROM address |
| rom_ce_n | output | 1 | EPROM chip enable, active low |
| rom_oe_n | output | 1 | EPROM output enable, active low |
| bus_drv_n | output | 1 | Data transceiver drive enable, active low |
| dev_sel_act | output | 1 | Qualified device select, for the controller |
| exp_rom_en | output | 1 | Expansion-ROM flag |

## Verification
The assertions rely on three properties of the host bus. I/O select and the I/O strobe are never low together. The address is stable while a strobe is held. The strobes change between clock edges. The stimulus meets these conditions by driving all inputs at the falling clock edge. It changes the address only when the strobe configuration changes, and it picks one strobe at a time. Strobe windows last from one to eight cycles, so glitches and long windows both occur.

// File: rtl/slot_glue_pkg.sv
package slot_glue_pkg;
   typedef enum logic [1:0] {
      STB_DEV = 2'd0,
      STB_IO  = 2'd1,
      STB_EXP = 2'd2
   } strobe_e;

   localparam int NUM_STROBES = 3;

   function automatic logic page_forced(input logic a_sel);
      return !a_sel;
   endfunction
endpackage

// File: rtl/slot_sel_sync.sv
module slot_sel_sync #(
   parameter int STAGES = 2,
   parameter int QUAL   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic active
);
   localparam int LEN = STAGES + QUAL - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slot_sel_sync: STAGES must be at least 2");
      end
      if (QUAL < 1) begin : g_bad_qual
         $error("slot_sel_sync: QUAL must be at least 1");
      end
   endgenerate

   logic [LEN-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[LEN-2:0], strobe_n};
   end

   assign active = ~|chain[LEN-1:STAGES-1];

   generate
      if (STAGES == 2 && QUAL == 2) begin : g_chk
         // R1: qualification needs low samples three and two edges back
         a_r1_qual_history: assert property (@(posedge clk) disable iff (!rst_n)
            active |-> (!$past(strobe_n, 2) && !$past(strobe_n, 3)));
         // R1: a high sample two edges back removes qualification
         a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
            $past(strobe_n, 2) |-> !active);
      end
   endgenerate
endmodule

// File: rtl/slot_rom_map.sv
module slot_rom_map #(
   parameter int ROM_AW = 11,
   parameter int PAGE_W = 3
) (
   input  logic [ROM_AW:0]   bus_a,
   output logic [ROM_AW-1:0] rom_a
);
   import slot_glue_pkg::*;
   localparam int LOW_W = ROM_AW - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= ROM_AW) begin : g_bad_page
         $error("slot_rom_map: PAGE_W out of range");
      end
   endgenerate

   logic forced;
   assign forced = page_forced(bus_a[ROM_AW]);

   always_comb begin
      rom_a[LOW_W-1:0]      = bus_a[LOW_W-1:0];
      rom_a[ROM_AW-1:LOW_W] = forced ? {PAGE_W{1'b1}} : bus_a[ROM_AW-1:LOW_W];
   end
endmodule

// File: rtl/slot_exp_flag.sv
module slot_exp_flag #(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] CLR_ADDR = 16'hCFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_act,
   input  logic              stb_act,
   input  logic [ADDR_W-1:0] addr,
   output logic              flag
);
   logic clr_hit;
   assign clr_hit = stb_act && (addr == CLR_ADDR[ADDR_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (clr_hit) flag <= 1'b0;
      else if (io_act)  flag <= 1'b1;
   end

   // R7: the clearing access empties the flag at the next edge
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_act && addr == CLR_ADDR[ADDR_W-1:0]) |=> !flag);
   // R6: a qualified slot select raises the flag
   a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
      (io_act && !stb_act) |=> flag);
endmodule

// File: rtl/slot_drv_gate.sv
module slot_drv_gate #(
   parameter int DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rom_sel,
   output logic drive
);
   generate
      if (DELAY < 0) begin : g_bad_delay
         $error("slot_drv_gate: DELAY must not be negative");
      end
      if (DELAY == 0) begin : g_direct
         assign drive = rom_sel;
      end else begin : g_delayed
         logic [DELAY-1:0] hist;
         if (DELAY == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) hist <= '0;
               else        hist <= rom_sel;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) hist <= '0;
               else        hist <= {hist[DELAY-2:0], rom_sel};
            end
         end
         assign drive = rom_sel & (&hist);
      end
   endgenerate
endmodule

// File: rtl/slot_rom_glue.sv
module slot_rom_glue #(
   parameter int          ADDR_W       = 16,
   parameter int          ROM_AW       = 11,
   parameter int          PAGE_W       = 3,
   parameter int          SYNC_STAGES  = 2,
   parameter int          QUAL_SAMPLES = 2,
   parameter int          DRV_DELAY    = 1,
   parameter logic [15:0] EXP_CLR_ADDR = 16'hCFFF
) (
   input  logic              clk_7m,
   input  logic              rst_n,
   input  logic              dev_sel_n,
   input  logic              io_sel_n,
   input  logic              io_stb_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_ce_n,
   output logic              rom_oe_n,
   output logic              bus_drv_n,
   output logic              dev_sel_act,
   output logic              exp_rom_en
);
   import slot_glue_pkg::*;

   generate
      if (ROM_AW + 1 > ADDR_W) begin : g_bad_aw
         $error("slot_rom_glue: ROM_AW too wide for ADDR_W");
      end
   endgenerate

   logic [NUM_STROBES-1:0] strobe_n;
   logic [NUM_STROBES-1:0] act;
   assign strobe_n[STB_DEV] = dev_sel_n;
   assign strobe_n[STB_IO]  = io_sel_n;
   assign strobe_n[STB_EXP] = io_stb_n;

   for (genvar i = 0; i < NUM_STROBES; i++) begin : g_sync
      slot_sel_sync #(.STAGES(SYNC_STAGES), .QUAL(QUAL_SAMPLES)) u_sync (
         .clk(clk_7m), .rst_n(rst_n), .strobe_n(strobe_n[i]), .active(act[i]));
   end

   slot_rom_map #(.ROM_AW(ROM_AW), .PAGE_W(PAGE_W)) u_map (
      .bus_a(addr[ROM_AW:0]), .rom_a(rom_addr));

   slot_exp_flag #(.ADDR_W(ADDR_W), .CLR_ADDR(EXP_CLR_ADDR)) u_flag (
      .clk(clk_7m), .rst_n(rst_n), .io_act(act[STB_IO]), .stb_act(act[STB_EXP]),
      .addr(addr), .flag(exp_rom_en));

   logic exp_hit, rom_sel, drive;
   assign exp_hit = act[STB_EXP] && exp_rom_en && addr[ROM_AW]
                    && (addr != EXP_CLR_ADDR[ADDR_W-1:0]);
   assign rom_sel = act[STB_IO] || exp_hit;

   slot_drv_gate #(.DELAY(DRV_DELAY)) u_drv (
      .clk(clk_7m), .rst_n(rst_n), .rom_sel(rom_sel), .drive(drive));

   assign rom_ce_n    = !rom_sel;
   assign rom_oe_n    = !rom_sel;
   assign bus_drv_n   = !drive;
   assign dev_sel_act = act[STB_DEV];

   // R4: slot-space accesses always land in the top ROM page
   a_r4_top_page: assert property (@(posedge clk_7m) disable iff (!rst_n)
      !addr[ROM_AW] |-> (&rom_addr[ROM_AW-1 -: PAGE_W]));
   // R9: no drive in the first cycle of a ROM window
   a_r9_withhold: assert property (@(posedge clk_7m) disable iff (!rst_n)
      $fell(rom_oe_n) |-> bus_drv_n);
   // R9: drive never outlasts the ROM window
   a_r9_release: assert property (@(posedge clk_7m) disable iff (!rst_n)
      rom_oe_n |-> bus_drv_n);
   generate
      if (DRV_DELAY == 1) begin : g_drv_chk
         // R9: drive is on from the second cycle of the window
         a_r9_drive_on: assert property (@(posedge clk_7m) disable iff (!rst_n)
            (!rom_oe_n && !$past(rom_oe_n)) |-> !bus_drv_n);
      end
   endgenerate
endmodule

// File: tb/slot_rom_glue_tb.sv
module slot_rom_glue_tb;
   localparam int CLK_PERIOD = 140;
   localparam logic [15:0] CLR = 16'hCFFF;

   logic clk_7m = 1'b0;
   logic rst_n = 1'b0;
   logic dev_sel_n = 1'b1, io_sel_n = 1'b1, io_stb_n = 1'b1;
   logic [15:0] addr = 16'h0000;
   logic [10:0] rom_addr;
   logic rom_ce_n, rom_oe_n, bus_drv_n, dev_sel_act, exp_rom_en;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk_7m = ~clk_7m;

   slot_rom_glue u_dut (
      .clk_7m(clk_7m), .rst_n(rst_n), .dev_sel_n(dev_sel_n), .io_sel_n(io_sel_n),
      .io_stb_n(io_stb_n), .addr(addr), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
      .rom_oe_n(rom_oe_n), .bus_drv_n(bus_drv_n), .dev_sel_act(dev_sel_act),
      .exp_rom_en(exp_rom_en));

   // reference model built from the requirements
   logic [2:0] h_dev = '1, h_io = '1, h_stb = '1;
   logic m_flag = 1'b0, m_dly = 1'b0;

   function automatic logic qual(input logic [2:0] h);
      return !h[1] && !h[2];
   endfunction

   function automatic logic rom_exp(input logic io_a, stb_a, fl, input logic [15:0] a);
      return io_a || (stb_a && fl && a[11] && a != CLR);
   endfunction

   function automatic logic [10:0] map_exp(input logic [15:0] a);
      return a[11] ? a[10:0] : {3'b111, a[7:0]};
   endfunction

   always @(posedge clk_7m) begin
      if (!rst_n) begin
         h_dev = '1; h_io = '1; h_stb = '1; m_flag = 1'b0; m_dly = 1'b0;
      end else begin
         m_dly = rom_exp(qual(h_io), qual(h_stb), m_flag, addr);
         if (qual(h_stb) && addr == CLR) m_flag = 1'b0;
         else if (qual(h_io))            m_flag = 1'b1;
         h_dev = {h_dev[1:0], dev_sel_n};
         h_io  = {h_io[1:0], io_sel_n};
         h_stb = {h_stb[1:0], io_stb_n};
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_check();
      logic rom;
      rom = rom_exp(qual(h_io), qual(h_stb), m_flag, addr);
      chk(addr[11] ? "R5" : "R4", "rom_addr", rom_addr, map_exp(addr));
      chk("R8", "rom_ce_n", rom_ce_n, !rom);
      chk("R8", "rom_oe_n", rom_oe_n, !rom);
      chk("R9", "bus_drv_n", bus_drv_n, !(rom && m_dly));
      chk("R3", "dev_sel_act", dev_sel_act, qual(h_dev));
      chk("R6", "exp_rom_en", exp_rom_en, m_flag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_7m);
   endtask

   initial begin
      void'($urandom(32'd5171));
      idle(3);
      chk("R10", "rom_ce_n in reset", rom_ce_n, 1'b1);
      chk("R10", "rom_oe_n in reset", rom_oe_n, 1'b1);
      chk("R10", "bus_drv_n in reset", bus_drv_n, 1'b1);
      chk("R10", "dev_sel_act in reset", dev_sel_act, 1'b0);
      chk("R10", "exp_rom_en in reset", exp_rom_en, 1'b0);
      rst_n = 1'b1;
      idle(4);

      // R2: single-cycle glitch on I/O select
      addr = 16'hC512; io_sel_n = 1'b0;
      @(negedge clk_7m); io_sel_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk_7m);
         chk("R2", "rom_ce_n after glitch", rom_ce_n, 1'b1);
      end
      chk("R2", "exp_rom_en after glitch", exp_rom_en, 1'b0);

      // R1 timing on device select
      dev_sel_n = 1'b0;
      @(negedge clk_7m); chk("R1", "dev act after 1 edge", dev_sel_act, 1'b0);
      @(negedge clk_7m); chk("R1", "dev act after 2 edges", dev_sel_act, 1'b0);
      @(negedge clk_7m); chk("R1", "dev act after 3 edges", dev_sel_act, 1'b1);
      dev_sel_n = 1'b1;
      @(negedge clk_7m); chk("R1", "dev act 1 edge after release", dev_sel_act, 1'b1);
      @(negedge clk_7m); chk("R1", "dev act 2 edges after release", dev_sel_act, 1'b0);
      idle(2);

      // R5/R4 combinational mapping, away from any edge
      #(CLK_PERIOD/4); addr = 16'hCA5B; #1;
      chk("R5", "rom_addr pass", rom_addr, 11'h25B);
      addr = 16'hC35B; #1;
      chk("R4", "rom_addr forced", rom_addr, 11'h75B);
      @(negedge clk_7m);

      // R9 window on I/O select, R6 flag set
      addr = 16'hC420; io_sel_n = 1'b0;
      idle(3);
      chk("R8", "rom_oe_n window open", rom_oe_n, 1'b0);
      chk("R9", "bus_drv_n withheld", bus_drv_n, 1'b1);
      chk("R6", "exp_rom_en not yet", exp_rom_en, 1'b0);
      idle(1);
      chk("R9", "bus_drv_n on", bus_drv_n, 1'b0);
      chk("R6", "exp_rom_en set", exp_rom_en, 1'b1);
      idle(2); io_sel_n = 1'b1;
      idle(1);
      chk("R9", "bus_drv_n still on", bus_drv_n, 1'b0);
      idle(1);
      chk("R9", "rom_oe_n closed", rom_oe_n, 1'b1);
      chk("R9", "bus_drv_n released with window", bus_drv_n, 1'b1);
      idle(2);

      // R8 expansion window with flag set
      addr = 16'hC9A0; io_stb_n = 1'b0;
      idle(3); chk("R8", "rom_ce_n expansion", rom_ce_n, 1'b0);
      io_stb_n = 1'b1; idle(3);

      // R7 clear access
      addr = CLR; io_stb_n = 1'b0;
      idle(3); chk("R7", "rom_ce_n on clear access", rom_ce_n, 1'b1);
      idle(1); chk("R7", "exp_rom_en cleared", exp_rom_en, 1'b0);
      io_stb_n = 1'b1; idle(3);
      addr = 16'hC9A0; io_stb_n = 1'b0;
      idle(3); chk("R7", "rom_ce_n expansion after clear", rom_ce_n, 1'b1);
      io_stb_n = 1'b1; idle(3);

      // constrained random phase, checked against the model
      begin
         int left = 0;
         for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk_7m);
            model_check();
            if (left == 0) begin
               int kind;
               kind = $urandom_range(0, 3);
               left = $urandom_range(1, 8);
               dev_sel_n = 1'b1; io_sel_n = 1'b1; io_stb_n = 1'b1;
               case (kind)
                  0: addr = 16'($urandom);
                  1: begin dev_sel_n = 1'b0; addr = 16'hC080 | 16'($urandom_range(0, 127)); end
                  2: begin io_sel_n = 1'b0; addr = 16'hC000 | 16'($urandom_range(256, 2047)); end
                  default: begin
                     io_stb_n = 1'b0;
                     if ($urandom_range(0, 7) == 0) addr = CLR;
                     else addr = 16'hC800 | 16'($urandom_range(0, 16'h6FF));
                  end
               endcase
            end else left--;
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule